// File: doc/BRIEF.md
# Bit-Serial Four-Function ALU

This block is a one-bit-wide arithmetic unit that works on 8-bit words delivered one bit per beat, least significant bit first. Each beat carries one accumulator bit and one bus bit. Each beat produces one result bit. A registered carry and a registered OR-accumulation are fed back from one beat to the next. With them, the single-bit datapath performs an 8-bit wrap-around addition and an 8-bit zero test. It can also pass either operand straight through. A build-time option replaces the accumulator pass-through with a bitwise AND of the two operand bits.

Operand beats enter on a valid/ready stream and result bits leave on a second valid/ready stream. The input side is ready whenever the single output register is empty or is being drained in the same cycle. While the consumer holds `out_ready` low, the pending result bit is frozen and no further beat is taken. The operation, frame and flag pins are plain levels and pulses outside the handshake. The selected operation stays in a register until it is rewritten, so a sequencer writes it once for any number of frames.

Top module: `serial_alu`

## Requirements
- R1: A beat is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` equals `!out_valid || out_ready`. The result bit of an accepted beat appears on `out_bit`, with `out_valid` high, right after that edge. After reset `out_valid` and `zero_flag` are low and `in_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bit` holds its value.
- R3: With operation code 0 (add), the result bits of one frame are bits 0..7 of the sum of the accumulator word and the bus word, least significant bit first. The carry passes from bit to bit, and the carry out of bit 7 is dropped, so the sum wraps modulo 256.
- R4: With operation code 1, each result bit equals the bus bit of the same beat.
- R5: With operation code 2, each result bit equals the accumulator bit of the same beat. When the parameter `USE_AND` is 1, the result bit is the AND of the accumulator bit and the bus bit instead.
- R6: With operation code 3 (zero check), each result bit is the OR of all accumulator bits received so far in the frame, including the current one.
- R7: After the 8th accepted beat of a frame, `zero_flag` is high exactly when all 8 accumulator bits of that frame were 0. It keeps that value until the next `frame_start` or until the 8th beat of a later frame.
- R8: A `frame_start` pulse clears the carry, the OR-accumulation, the bit count and `zero_flag`. A beat accepted in the same cycle as `frame_start` is processed as bit 0 of the new frame, using the cleared state.
- R9: A beat accepted after 8 beats of a frame, with no `frame_start` in between, begins a new frame with a cleared carry and a cleared OR-accumulation.
- R10: `op_wr` loads `op_sel` into the operation register, which resets to code 0. The selection holds across any number of frames. A beat accepted in the same cycle as `op_wr` uses the previous selection.
- R11: Cycles with no accepted beat, whether `in_valid` is low or the output is stalled, leave the carry, the OR-accumulation and the bit count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_wr | input | 1 | Load strobe for the operation register |
| op_sel | input | 2 | Operation code: 0 add, 1 bus pass, 2 accumulator pass (or AND), 3 zero check |
| frame_start | input | 1 | Clears the per-frame state; a beat accepted in the same cycle becomes bit 0 |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block can accept an operand beat |
| acc_bit | input | 1 | Accumulator operand bit, least significant first |
| bus_bit | input | 1 | Bus operand bit, least significant first |
| out_valid | output | 1 | Result bit present |
| out_ready | input | 1 | Consumer takes the result bit |
| out_bit | output | 1 | Result bit |
| zero_flag | output | 1 | Accumulator word of the last completed frame was zero |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a `frame_start` pulse and an accepted beat. The bench raises `frame_start` on the first beat of a frame that directly follows a partial frame, which leaves a non-zero carry behind. That frame's add result must then match a fresh word sum. The second pair is an `op_wr` and an accepted beat. The bench writes a new operation on the same beat and checks that the beat's result bit follows the old operation while the next beat follows the new one. All of this runs while the output side is stalled by a pseudo-random ready pattern, so acceptance is delayed across several clock edges.

// File: rtl/serial_alu_pkg.sv
package serial_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD    = 2'd0,
    OP_PASS_D = 2'd1,
    OP_PASS_A = 2'd2,
    OP_ZERO   = 2'd3
  } alu_op_e;
endpackage

// File: rtl/serial_alu_opreg.sv
module serial_alu_opreg
  import serial_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_wr,
  input  logic [1:0] op_sel,
  output alu_op_e    op_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     op_q <= OP_ADD;
    else if (op_wr) op_q <= alu_op_e'(op_sel);
  end

  AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_wr |=> $stable(op_q)); // R10
  AST_OP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    op_wr |=> (op_q == alu_op_e'($past(op_sel)))); // R10
endmodule

// File: rtl/serial_alu_core.sv
module serial_alu_core
  import serial_alu_pkg::*;
#(
  parameter int WORD_BITS = 8,
  parameter bit USE_AND   = 1'b0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fire,
  input  logic    frame_start,
  input  alu_op_e op,
  input  logic    a_bit,
  input  logic    d_bit,
  output logic    res_bit,
  output logic    zero_flag
);
  localparam int CNT_W = $clog2(WORD_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS);

  logic             carry_q, zacc_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             fresh, cin, zin, sum, cout, third;

  // Frame boundary: explicit pulse or a completed word
  assign fresh  = frame_start || (cnt_q == LAST);
  assign cin    = fresh ? 1'b0 : carry_q;
  assign zin    = fresh ? 1'b0 : zacc_q;
  assign sum    = a_bit ^ d_bit ^ cin;
  assign cout   = (a_bit & d_bit) | (cin & (a_bit ^ d_bit));
  assign cnt_nx = fresh ? CNT_W'(1) : cnt_q + CNT_W'(1);

  generate
    if (USE_AND) begin : g_and
      assign third = a_bit & d_bit;
    end else begin : g_pass
      assign third = a_bit;
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_ADD:    res_bit = sum;
      OP_PASS_D: res_bit = d_bit;
      OP_PASS_A: res_bit = third;
      default:   res_bit = zin | a_bit;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q   <= 1'b0;
      zacc_q    <= 1'b0;
      cnt_q     <= '0;
      zero_flag <= 1'b0;
    end else begin
      if (frame_start) begin
        carry_q   <= 1'b0;
        zacc_q    <= 1'b0;
        cnt_q     <= '0;
        zero_flag <= 1'b0;
      end
      if (fire) begin
        carry_q <= cout;
        zacc_q  <= zin | a_bit;
        cnt_q   <= cnt_nx;
        if (cnt_nx == LAST) zero_flag <= !(zin | a_bit);
      end
    end
  end

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !frame_start) |=> ($stable(carry_q) && $stable(zacc_q) && $stable(cnt_q))); // R11
  AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !fire) |=> (!carry_q && !zacc_q && cnt_q == '0 && !zero_flag)); // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !(fire && cnt_nx == LAST)) |=> $stable(zero_flag)); // R7
endmodule

// File: rtl/serial_alu_outreg.sv
module serial_alu_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic res_bit,
  input  logic out_ready,
  output logic out_valid,
  output logic out_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_bit   <= res_bit;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit))); // R2
  AST_OUT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid); // R1
endmodule

// File: rtl/serial_alu.sv
module serial_alu
  import serial_alu_pkg::*;
#(
  parameter int WORD_BITS = 8,
  parameter bit USE_AND   = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_wr,
  input  logic [1:0] op_sel,
  input  logic       frame_start,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       acc_bit,
  input  logic       bus_bit,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_bit,
  output logic       zero_flag
);
  alu_op_e op_q;
  logic    fire, res_bit;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  serial_alu_opreg u_opreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_wr  (op_wr),
    .op_sel (op_sel),
    .op_q   (op_q)
  );

  serial_alu_core #(.WORD_BITS(WORD_BITS), .USE_AND(USE_AND)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .frame_start (frame_start),
    .op          (op_q),
    .a_bit       (acc_bit),
    .d_bit       (bus_bit),
    .res_bit     (res_bit),
    .zero_flag   (zero_flag)
  );

  serial_alu_outreg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .res_bit   (res_bit),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_bit   (out_bit)
  );

  AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && in_valid) |=> $stable(out_bit)); // R2
endmodule

// File: tb/tb_serial_alu.sv
module tb_serial_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_wr = 1'b0;
  logic [1:0] op_sel = 2'd0;
  logic frame_start = 1'b0;
  logic in_valid = 1'b0;
  logic acc_bit = 1'b0, bus_bit = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_bit, zero_flag;
  logic in_ready2, out_valid2, out_bit2, zero_flag2;

  int n_chk = 0, n_bad = 0;
  logic [1:0] expq[$];
  string      tagq[$];
  logic       stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  serial_alu dut (
    .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_sel(op_sel), .frame_start(frame_start),
    .in_valid(in_valid), .in_ready(in_ready), .acc_bit(acc_bit), .bus_bit(bus_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .zero_flag(zero_flag)
  );

  serial_alu #(.USE_AND(1'b1)) dut_and (
    .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_sel(op_sel), .frame_start(frame_start),
    .in_valid(in_valid), .in_ready(in_ready2), .acc_bit(acc_bit), .bus_bit(bus_bit),
    .out_valid(out_valid2), .out_ready(out_ready), .out_bit(out_bit2), .zero_flag(zero_flag2)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // Consumer ready pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= stall_en ? lfsr[0] : 1'b1;
  end

  // Monitor: pops expected items as results are handed over
  logic prev_stall = 1'b0, prev_bit = 1'b0;
  initial begin
    forever begin
      @(negedge clk); #4;
      if (rst_n) begin
        if (prev_stall) check(out_valid && out_bit == prev_bit, "R2", out_bit, prev_bit);
        check(in_ready == (!out_valid || out_ready), "R1", in_ready, !out_valid || out_ready);
        if (out_valid && out_ready) begin
          if (expq.size() == 0) check(1'b0, "R1", 1, 0);
          else begin
            logic [1:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(out_bit == e[0], t, out_bit, e[0]);
            check(out_valid2 && out_bit2 == e[1], t, out_bit2, e[1]);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_bit   = out_bit;
      end
    end
  end

  // Driver: called at a negedge, returns at the negedge after acceptance
  task automatic send_beat(input logic a, input logic d, input logic fs, input logic wr,
                           input logic [1:0] wsel, input logic em, input logic ea,
                           input string rq);
    acc_bit = a; bus_bit = d; frame_start = fs; op_wr = wr; op_sel = wsel; in_valid = 1'b1;
    forever begin
      #4;
      if (in_ready) break;
      @(negedge clk);
    end
    expq.push_back({ea, em});
    tagq.push_back(rq);
    @(negedge clk);
    in_valid = 1'b0; frame_start = 1'b0; op_wr = 1'b0;
  endtask

  task automatic write_op(input logic [1:0] v);
    op_wr = 1'b1; op_sel = v;
    @(negedge clk);
    op_wr = 1'b0;
  endtask

  task automatic pulse_frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // One word: expectations from the word-level definition of each operation
  task automatic run_frame(input int op, input logic [7:0] A, input logic [7:0] D,
                           input logic fs_first, input int gap, input string rq);
    logic [7:0] s;
    s = A + D;
    for (int i = 0; i < 8; i++) begin
      logic em, ea;
      case (op)
        0: em = s[i];
        1: em = D[i];
        2: em = A[i];
        default: em = |(A & ((8'd2 << i) - 8'd1));
      endcase
      ea = (op == 2) ? (A[i] & D[i]) : em;
      send_beat(A[i], D[i], fs_first && i == 0, 1'b0, 2'd0, em, ea, rq);
      repeat (gap) @(negedge clk);
    end
    check(zero_flag == (A == 8'd0), "R7", zero_flag, A == 8'd0);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin @(posedge clk); wd++; end
    if (!done) begin
      check(1'b0, "watchdog", wd, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(zero_flag == 1'b0, "R1", zero_flag, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", in_ready, 1);

    // R3 add after reset (reset op is add), wrap-around
    run_frame(0, 8'hFF, 8'h01, 1'b1, 0, "R3");
    run_frame(0, 8'h5A, 8'h3C, 1'b0, 0, "R3");   // R9 implicit new frame
    run_frame(0, 8'h00, 8'h00, 1'b0, 0, "R9");
    check(zero_flag == 1'b1, "R7", zero_flag, 1);
    // R7 flag holds through idle; R8 pulse clears it
    repeat (3) @(negedge clk);
    check(zero_flag == 1'b1, "R7", zero_flag, 1);
    pulse_frame();
    check(zero_flag == 1'b0, "R8", zero_flag, 0);

    // R4, R5, R6 and R10 persistence
    write_op(2'd1);
    run_frame(1, 8'hC3, 8'h96, 1'b1, 0, "R4");
    run_frame(1, 8'h11, 8'h7E, 1'b1, 0, "R10");
    write_op(2'd2);
    run_frame(2, 8'hB5, 8'h6D, 1'b1, 0, "R5");
    write_op(2'd3);
    run_frame(3, 8'h00, 8'hFF, 1'b1, 0, "R6");
    run_frame(3, 8'h40, 8'h00, 1'b1, 0, "R6");
    run_frame(3, 8'h01, 8'h00, 1'b1, 0, "R6");

    // R11 and R2: gaps and output stalls inside an add frame
    write_op(2'd0);
    stall_en = 1'b1;
    run_frame(0, 8'h77, 8'h99, 1'b1, 3, "R11");
    run_frame(0, 8'hE4, 8'h2B, 1'b1, 0, "R2");

    // R8: partial frame leaves carry set, frame_start on the same beat as bit 0
    send_beat(1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, "R3");
    send_beat(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, "R3");
    run_frame(0, 8'h01, 8'h02, 1'b1, 0, "R8");

    // R10: op write on the same beat uses the old op
    write_op(2'd1);
    send_beat(1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, "R10");
    send_beat(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, "R10");
    stall_en = 1'b0;

    repeat (20) @(negedge clk);
    check(expq.size() == 0, "R1", expq.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule